// File: doc/BRIEF.md
# Graph Edge Scatter Engine

This block is one streaming stage of a graph-processing pipeline. It consumes the directed edges of one graph partition, one edge per handshake, together with a separate stream of edge weights that is kept in step with the edge stream. For every edge it looks up the property of the source vertex and combines that property with the weight. The result is an update tuple made of the destination vertex id and the computed value. The tuples are sent to a downstream dispatch stage on a valid/ready stream.

Source properties are looked up in a small direct-mapped cache with one property per line. When a lookup misses, the block issues a single read to a backing memory port whose data returns a fixed, parameterised number of cycles later. It stalls until that data arrives, fills the line, and then continues. The stage holds one edge at a time, so tuples always leave in the order their edges arrived. Each edge carries a 2-bit function select that picks the update function applied to it. Between graph iterations an invalidate pulse empties the cache, so that the next iteration reads fresh properties.

Top module: `edge_scatter_engine`

## Requirements
- R1: Every accepted edge produces exactly one output tuple. Tuples leave in acceptance order, and each tuple's destination field equals its edge's destination id.
- R2: Function select code 00 outputs the source property unchanged.
- R3: Function select code 01 outputs the source property plus the zero-extended weight, modulo 2^PROP_W.
- R4: Function select code 10 outputs the product of property and weight shifted right by FRAC_W bits, keeping the low PROP_W bits.
- R5: Function select code 11 outputs the source property plus one, modulo 2^PROP_W.
- R6: An edge and a weight are taken only together. `edge_ready` and `wgt_ready` are always equal, and an edge without a weight (or a weight without an edge) is not consumed.
- R7: On a cache hit with the stage idle and the output free, the tuple becomes valid two clock edges after the acceptance edge, counting that edge. Back-to-back hits sustain one edge per cycle.
- R8: A miss issues exactly one memory read, whose address is the source id. No further read is issued while one is outstanding. The data is taken MEM_LAT cycles after the request cycle, and the tuple appears MEM_LAT+3 edges after acceptance. `edge_ready` is low while the read is being requested.
- R9: The cache line index is the low log2(LINES) bits of the source id. A different source id with the same index evicts the line, so returning to the first id misses again.
- R10: While `upd_valid` is high and `upd_ready` is low, the tuple stays unchanged. With the stage and the output both occupied, `edge_ready` is low.
- R11: An invalidate pulse empties every line. The next lookup of any id misses and re-reads memory, picking up the memory's current contents.
- R12: After reset, `upd_valid` and `mem_rd_en` are low, `edge_ready` is high and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| invalidate | input | 1 | Empties all cache lines |
| edge_valid | input | 1 | Edge stream valid |
| edge_ready | output | 1 | Edge stream ready |
| edge_src | input | VID_W | Source vertex id |
| edge_dst | input | VID_W | Destination vertex id |
| edge_func | input | 2 | Update function select for this edge |
| wgt_valid | input | 1 | Weight stream valid |
| wgt_ready | output | 1 | Weight stream ready |
| wgt_data | input | WGT_W | Edge weight |
| mem_rd_en | output | 1 | Backing memory read request |
| mem_rd_addr | output | VID_W | Backing memory read address (vertex id) |
| mem_rd_data | input | PROP_W | Read data, valid MEM_LAT cycles after the request |
| upd_valid | output | 1 | Update tuple valid |
| upd_ready | input | 1 | Downstream ready |
| upd_dst | output | VID_W | Tuple destination vertex id |
| upd_value | output | PROP_W | Tuple computed value |

## Verification
The bench builds the engine with LINES=4, MEM_LAT=3, VID_W=8, PROP_W=16, WGT_W=8 and FRAC_W=4. The four-line cache makes evictions between ids that share an index frequent under a random source range of a dozen vertices. The three-cycle latency makes miss stalls long enough to overlap with random downstream back-pressure. The small property width lets the add, increment and fixed-point product modes wrap around.

// File: rtl/edge_scatter_pkg.sv
package edge_scatter_pkg;

    // Per-edge update function select
    typedef enum logic [1:0] {
        UPD_PASS = 2'b00,
        UPD_ADD  = 2'b01,
        UPD_MUL  = 2'b10,
        UPD_INC  = 2'b11
    } upd_mode_e;

    // Miss handling state of the property cache
    typedef enum logic {
        FETCH_IDLE = 1'b0,
        FETCH_WAIT = 1'b1
    } fetch_state_e;

    // Index width helper, never below one bit
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/esc_update_alu.sv
module esc_update_alu
    import edge_scatter_pkg::*;
#(
    parameter int unsigned PROP_W = 16,
    parameter int unsigned WGT_W  = 8,
    parameter int unsigned FRAC_W = 4
) (
    input  upd_mode_e          mode,
    input  logic [PROP_W-1:0]  prop,
    input  logic [WGT_W-1:0]   wgt,
    output logic [PROP_W-1:0]  value
);
    localparam int unsigned PROD_W = PROP_W + WGT_W;

    logic [PROD_W-1:0] prod_full;
    logic [PROD_W-1:0] prod_shift;
    logic [PROP_W-1:0] wgt_ext;

    always_comb begin
        wgt_ext    = PROP_W'(wgt);
        prod_full  = PROD_W'(prop) * PROD_W'(wgt);
        prod_shift = prod_full >> FRAC_W;
        unique case (mode)
            UPD_PASS: value = prop;
            UPD_ADD:  value = prop + wgt_ext;
            UPD_MUL:  value = prod_shift[PROP_W-1:0];
            UPD_INC:  value = prop + PROP_W'(1);
            default:  value = prop;
        endcase
    end

endmodule

// File: rtl/esc_prop_cache.sv
module esc_prop_cache
    import edge_scatter_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned LINES   = 16,
    parameter int unsigned MEM_LAT = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               invalidate,
    input  logic               lk_valid,
    input  logic [ADDR_W-1:0]  lk_addr,
    output logic               lk_hit,
    output logic [DATA_W-1:0]  lk_data,
    output logic               mem_rd_en,
    output logic [ADDR_W-1:0]  mem_rd_addr,
    input  logic [DATA_W-1:0]  mem_rd_data
);
    localparam int unsigned IDX_W = idx_bits(LINES);
    localparam int unsigned TAG_W = ADDR_W - IDX_W;
    localparam int unsigned CNT_W = idx_bits(MEM_LAT);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(MEM_LAT - 1);

    logic              line_vld [LINES];
    logic [TAG_W-1:0]  line_tag [LINES];
    logic [DATA_W-1:0] line_dat [LINES];

    fetch_state_e      fst;
    logic [CNT_W-1:0]  wait_cnt;
    logic [ADDR_W-1:0] pend_addr;
    logic              fill_en;

    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic [IDX_W-1:0]  pend_idx;
    logic [TAG_W-1:0]  pend_tag;

    assign lk_idx   = lk_addr[IDX_W-1:0];
    assign lk_tag   = lk_addr[ADDR_W-1:IDX_W];
    assign pend_idx = pend_addr[IDX_W-1:0];
    assign pend_tag = pend_addr[ADDR_W-1:IDX_W];

    // Lookup
    assign lk_hit  = line_vld[lk_idx] && (line_tag[lk_idx] == lk_tag);
    assign lk_data = line_dat[lk_idx];

    // Miss request: only when nothing is outstanding
    assign mem_rd_en   = lk_valid && !lk_hit && (fst == FETCH_IDLE);
    assign mem_rd_addr = lk_addr;

    // Data is present in the cycle where the countdown reaches zero
    assign fill_en = (fst == FETCH_WAIT) && (wait_cnt == '0) && !invalidate;

    always_ff @(posedge clk) begin
        if (rst) begin
            fst       <= FETCH_IDLE;
            wait_cnt  <= '0;
            pend_addr <= '0;
        end else begin
            unique case (fst)
                FETCH_IDLE: begin
                    if (mem_rd_en) begin
                        fst       <= FETCH_WAIT;
                        wait_cnt  <= CNT_LOAD;
                        pend_addr <= lk_addr;
                    end
                end
                FETCH_WAIT: begin
                    if (wait_cnt == '0) fst <= FETCH_IDLE;
                    else                wait_cnt <= wait_cnt - CNT_W'(1);
                end
                default: fst <= FETCH_IDLE;
            endcase
        end
    end

    // Line storage, one register set per line
    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst || invalidate)
                line_vld[g] <= 1'b0;
            else if (fill_en && (pend_idx == IDX_W'(g)))
                line_vld[g] <= 1'b1;
        end
        always_ff @(posedge clk) begin
            if (fill_en && (pend_idx == IDX_W'(g))) begin
                line_tag[g] <= pend_tag;
                line_dat[g] <= mem_rd_data;
            end
        end
    end

    // A request is never followed directly by another one
    assert_single_read_R8: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en);

    // A completed fill turns the stalled lookup into a hit
    assert_fill_then_hit_R8: assert property (@(posedge clk) disable iff (rst)
        (fill_en && lk_valid) |=> (lk_valid && lk_hit));

    // After invalidation nothing hits
    assert_inval_empties_R11: assert property (@(posedge clk) disable iff (rst)
        $past(invalidate) |-> !lk_hit);

endmodule

// File: rtl/edge_scatter_engine.sv
module edge_scatter_engine
    import edge_scatter_pkg::*;
#(
    parameter int unsigned VID_W   = 12,
    parameter int unsigned PROP_W  = 16,
    parameter int unsigned WGT_W   = 8,
    parameter int unsigned FRAC_W  = 4,
    parameter int unsigned LINES   = 16,
    parameter int unsigned MEM_LAT = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               invalidate,
    input  logic               edge_valid,
    output logic               edge_ready,
    input  logic [VID_W-1:0]   edge_src,
    input  logic [VID_W-1:0]   edge_dst,
    input  logic [1:0]         edge_func,
    input  logic               wgt_valid,
    output logic               wgt_ready,
    input  logic [WGT_W-1:0]   wgt_data,
    output logic               mem_rd_en,
    output logic [VID_W-1:0]   mem_rd_addr,
    input  logic [PROP_W-1:0]  mem_rd_data,
    output logic               upd_valid,
    input  logic               upd_ready,
    output logic [VID_W-1:0]   upd_dst,
    output logic [PROP_W-1:0]  upd_value
);
    typedef struct packed {
        logic [VID_W-1:0] src;
        logic [VID_W-1:0] dst;
        logic [WGT_W-1:0] wgt;
        upd_mode_e        mode;
    } hold_t;

    typedef struct packed {
        logic [VID_W-1:0]  dst;
        logic [PROP_W-1:0] value;
    } tuple_t;

    logic   hold_vld;
    hold_t  hold_q;
    logic   out_vld;
    tuple_t out_q;

    logic              lk_hit;
    logic [PROP_W-1:0] lk_data;
    logic [PROP_W-1:0] alu_value;

    logic out_free;
    logic hold_done;
    logic take_ok;
    logic accept;

    assign out_free  = !out_vld || upd_ready;
    assign hold_done = hold_vld && lk_hit && out_free;
    assign take_ok   = !hold_vld || hold_done;
    assign accept    = edge_valid && wgt_valid && take_ok;

    assign edge_ready = take_ok;
    assign wgt_ready  = take_ok;

    esc_prop_cache #(
        .ADDR_W  (VID_W),
        .DATA_W  (PROP_W),
        .LINES   (LINES),
        .MEM_LAT (MEM_LAT)
    ) i_cache (
        .clk         (clk),
        .rst         (rst),
        .invalidate  (invalidate),
        .lk_valid    (hold_vld),
        .lk_addr     (hold_q.src),
        .lk_hit      (lk_hit),
        .lk_data     (lk_data),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data)
    );

    esc_update_alu #(
        .PROP_W (PROP_W),
        .WGT_W  (WGT_W),
        .FRAC_W (FRAC_W)
    ) i_alu (
        .mode  (hold_q.mode),
        .prop  (lk_data),
        .wgt   (hold_q.wgt),
        .value (alu_value)
    );

    // Single edge holding stage, waits here during a miss
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_vld <= 1'b0;
            hold_q   <= '0;
        end else if (accept) begin
            hold_vld    <= 1'b1;
            hold_q.src  <= edge_src;
            hold_q.dst  <= edge_dst;
            hold_q.wgt  <= wgt_data;
            hold_q.mode <= upd_mode_e'(edge_func);
        end else if (hold_done) begin
            hold_vld <= 1'b0;
        end
    end

    // Output tuple register
    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            out_q   <= '0;
        end else if (hold_done) begin
            out_vld     <= 1'b1;
            out_q.dst   <= hold_q.dst;
            out_q.value <= alu_value;
        end else if (upd_ready) begin
            out_vld <= 1'b0;
        end
    end

    assign upd_valid = out_vld;
    assign upd_dst   = out_q.dst;
    assign upd_value = out_q.value;

    assert_tuple_held_R10: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_ready) |=>
            (upd_valid && $stable(upd_dst) && $stable(upd_value)));

    assert_ready_low_full_R10: assert property (@(posedge clk) disable iff (rst)
        (hold_vld && upd_valid && !upd_ready) |-> !edge_ready);

    assert_ready_low_miss_R8: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> (!edge_ready && !wgt_ready));

    assert_reset_idle_R12: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!upd_valid && !mem_rd_en && edge_ready));

endmodule

// File: tb/test_edge_scatter_engine.sv
module test_edge_scatter_engine;
    localparam int CLK_PERIOD = 10;
    localparam int VID_W   = 8;
    localparam int PROP_W  = 16;
    localparam int WGT_W   = 8;
    localparam int FRAC_W  = 4;
    localparam int LINES   = 4;
    localparam int MEM_LAT = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic invalidate = 1'b0;
    logic edge_valid = 1'b0;
    logic edge_ready;
    logic [VID_W-1:0] edge_src = '0;
    logic [VID_W-1:0] edge_dst = '0;
    logic [1:0] edge_func = '0;
    logic wgt_valid = 1'b0;
    logic wgt_ready;
    logic [WGT_W-1:0] wgt_data = '0;
    logic mem_rd_en;
    logic [VID_W-1:0] mem_rd_addr;
    logic [PROP_W-1:0] mem_rd_data;
    logic upd_valid;
    logic upd_ready = 1'b1;
    logic [VID_W-1:0] upd_dst;
    logic [PROP_W-1:0] upd_value;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int salt = 0;
    int bp_pct = 0;
    bit stall = 1'b0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    edge_scatter_engine #(
        .VID_W(VID_W), .PROP_W(PROP_W), .WGT_W(WGT_W),
        .FRAC_W(FRAC_W), .LINES(LINES), .MEM_LAT(MEM_LAT)
    ) i_edge_scatter_engine (
        .clk(clk), .rst(rst), .invalidate(invalidate),
        .edge_valid(edge_valid), .edge_ready(edge_ready),
        .edge_src(edge_src), .edge_dst(edge_dst), .edge_func(edge_func),
        .wgt_valid(wgt_valid), .wgt_ready(wgt_ready), .wgt_data(wgt_data),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .upd_valid(upd_valid), .upd_ready(upd_ready),
        .upd_dst(upd_dst), .upd_value(upd_value)
    );

    // Backing memory: contents are a function of address and iteration salt
    function automatic logic [PROP_W-1:0] mem_fn(input int addr, input int s);
        return PROP_W'(addr * 977 + s * 4099 + 5);
    endfunction

    logic [VID_W-1:0] rd_pipe [MEM_LAT];
    always @(posedge clk) begin
        rd_pipe[0] <= mem_rd_addr;
        for (int k = 1; k < MEM_LAT; k++) rd_pipe[k] <= rd_pipe[k-1];
    end
    assign mem_rd_data = mem_fn(int'(rd_pipe[MEM_LAT-1]), salt);

    // Behavioural reference: cache contents and expected streams
    bit  m_vld [LINES];
    int  m_tag [LINES];
    int  m_dat [LINES];
    int  exp_dst [$];
    int  exp_val [$];
    int  exp_mode [$];
    int  exp_req [$];
    int  acc_cyc = 0;

    function automatic int ref_val(input int mode, input int prop, input int w);
        case (mode)
            0: return prop;
            1: return (prop + w) % 65536;
            2: return ((prop * w) >> FRAC_W) % 65536;
            default: return (prop + 1) % 65536;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    task automatic model_accept(input int src, input int dst, input int w, input int mode);
        int idx;
        idx = src % LINES;
        if (!(m_vld[idx] && m_tag[idx] == src)) begin
            exp_req.push_back(src);
            m_vld[idx] = 1'b1;
            m_tag[idx] = src;
            m_dat[idx] = int'(mem_fn(src, salt));
        end
        exp_dst.push_back(dst);
        exp_val.push_back(ref_val(mode, m_dat[idx], w));
        exp_mode.push_back(mode);
        acc_cyc = cyc;
    endtask

    // Called at a negedge; returns at the negedge after the accepting edge
    task automatic send_edge(input int src, input int dst, input int w, input int mode);
        bit done;
        done = 1'b0;
        edge_valid = 1'b1; wgt_valid = 1'b1;
        edge_src = VID_W'(src); edge_dst = VID_W'(dst);
        wgt_data = WGT_W'(w); edge_func = 2'(mode);
        while (!done) begin
            #1;
            if (edge_ready) begin
                model_accept(src, dst, w, mode);
                done = 1'b1;
            end
            @(posedge clk);
            @(negedge clk);
        end
        edge_valid = 1'b0; wgt_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_dst.size() != 0 || upd_valid) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic do_invalidate();
        invalidate = 1'b1;
        @(posedge clk);
        @(negedge clk);
        invalidate = 1'b0;
        for (int i = 0; i < LINES; i++) m_vld[i] = 1'b0;
    endtask

    // Per-clock monitor: downstream ready, tuple and read comparison
    bit               prev_stall = 1'b0;
    logic [VID_W-1:0] prev_dst;
    logic [PROP_W-1:0] prev_val;
    always @(negedge clk) begin
        if (stall)            upd_ready = 1'b0;
        else if (bp_pct > 0)  upd_ready = (($urandom % 100) >= bp_pct);
        else                  upd_ready = 1'b1;
        #2;
        if (!rst) begin
            if (prev_stall) begin
                // R10: a stalled tuple stays in place
                check(upd_valid && upd_dst == prev_dst && upd_value == prev_val,
                      "R10 held tuple", int'(upd_value), int'(prev_val));
            end
            prev_stall = upd_valid && !upd_ready;
            prev_dst = upd_dst;
            prev_val = upd_value;
            // R6: the two ready signals agree
            if (edge_ready != wgt_ready)
                check(1'b0, "R6 ready pair", int'(wgt_ready), int'(edge_ready));
            if (upd_valid && upd_ready) begin
                if (exp_dst.size() == 0) begin
                    check(1'b0, "R1 unexpected tuple", int'(upd_dst), -1);
                end else begin
                    int ed, ev, em;
                    ed = exp_dst.pop_front();
                    ev = exp_val.pop_front();
                    em = exp_mode.pop_front();
                    check(int'(upd_dst) == ed, "R1 order/destination", int'(upd_dst), ed);
                    case (em)
                        0: check(int'(upd_value) == ev, "R2 pass value", int'(upd_value), ev);
                        1: check(int'(upd_value) == ev, "R3 add value", int'(upd_value), ev);
                        2: check(int'(upd_value) == ev, "R4 product value", int'(upd_value), ev);
                        default: check(int'(upd_value) == ev, "R5 increment value", int'(upd_value), ev);
                    endcase
                end
            end
            if (mem_rd_en) begin
                if (exp_req.size() == 0) begin
                    check(1'b0, "R8 unexpected read", int'(mem_rd_addr), -1);
                end else begin
                    int ea;
                    ea = exp_req.pop_front();
                    check(int'(mem_rd_addr) == ea, "R9 read address", int'(mem_rd_addr), ea);
                    check(!edge_ready, "R8 ready during miss", int'(edge_ready), 0);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int lat;
        for (int i = 0; i < LINES; i++) begin m_vld[i] = 1'b0; m_tag[i] = 0; m_dat[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R12: reset state
        check(!upd_valid, "R12 upd_valid after reset", int'(upd_valid), 0);
        check(!mem_rd_en, "R12 mem_rd_en after reset", int'(mem_rd_en), 0);
        check(edge_ready, "R12 edge_ready after reset", int'(edge_ready), 1);
        @(negedge clk);

        // R8: first access misses, latency MEM_LAT+3
        send_edge(2, 40, 3, 0);
        while (!upd_valid) @(negedge clk);
        lat = cyc - acc_cyc;
        check(lat == MEM_LAT + 3, "R8 miss latency", lat, MEM_LAT + 3);
        drain();

        // R7: hit latency of two edges
        send_edge(2, 41, 7, 1);
        while (!upd_valid) @(negedge clk);
        lat = cyc - acc_cyc;
        check(lat == 2, "R7 hit latency", lat, 2);
        drain();

        // R2..R5 directed on a cached line, back to back (R7 throughput)
        send_edge(2, 50, 200, 0);
        send_edge(2, 51, 255, 1);
        send_edge(2, 52, 255, 2);
        send_edge(2, 53, 0, 3);
        drain();

        // R9: ids 1 and 5 share line 1 with four lines
        send_edge(1, 60, 1, 3);
        send_edge(5, 61, 1, 3);
        send_edge(1, 62, 1, 3);
        drain();
        check(exp_req.size() == 0, "R9 reads consumed", exp_req.size(), 0);

        // R6: edge without weight, then weight without edge
        edge_valid = 1'b1; edge_src = 8'd3; edge_dst = 8'd70; edge_func = 2'd0;
        repeat (5) @(negedge clk);
        #1;
        check(!upd_valid && !mem_rd_en, "R6 edge alone not taken", int'(upd_valid), 0);
        edge_valid = 1'b0; wgt_valid = 1'b1; wgt_data = 8'd9;
        repeat (5) @(negedge clk);
        #1;
        check(!upd_valid && !mem_rd_en, "R6 weight alone not taken", int'(upd_valid), 0);
        wgt_valid = 1'b0;
        @(negedge clk);

        // R10: downstream stalled, stage fills, ready drops
        stall = 1'b1;
        send_edge(2, 80, 1, 0);
        send_edge(2, 81, 1, 0);
        repeat (3) @(negedge clk);
        #1;
        check(!edge_ready, "R10 ready low when full", int'(edge_ready), 0);
        check(upd_valid && upd_dst == 8'd80, "R10 stalled tuple", int'(upd_dst), 80);
        stall = 1'b0;
        drain();

        // Random traffic with back-pressure (R1..R5, R8, R9)
        bp_pct = 35;
        for (int n = 0; n < 300; n++)
            send_edge($urandom % 12, $urandom % 256, $urandom % 256, $urandom % 4);
        drain();

        // Memory changes without invalidation: cached values stay in use
        salt = 1;
        send_edge(2, 90, 0, 0);
        drain();

        // R11: invalidate, then the new contents are read
        do_invalidate();
        send_edge(2, 91, 0, 0);
        drain();
        check(exp_req.size() == 0, "R11 refetch after invalidate", exp_req.size(), 0);

        // Second iteration of random traffic
        for (int n = 0; n < 150; n++)
            send_edge($urandom % 10, $urandom % 256, $urandom % 256, $urandom % 4);
        bp_pct = 0;
        drain();

        check(exp_dst.size() == 0, "R1 all tuples delivered", exp_dst.size(), 0);
        check(exp_req.size() == 0, "R8 all reads issued", exp_req.size(), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule